// File: doc/BRIEF.md
# Privileged Trap Entry Sequencer

This block redirects a core's program counter when a fault, interrupt or privileged call is taken, and again when the handler executes its return-from-exception operation. For a trap it adds a fixed per-cause vector offset to a programmable handler base. It records the address at which execution must resume and switches the core into privileged mode. Privileged mode is carried in bit 0 of the program counter, and every vector offset has that bit set.

A small integer register file sits inside the block. Registers 8 to 14 and register 25 each have a second, shadow copy. While the shadow bank is active, reads and writes to those indices reach the shadow copy. Entering privileged mode from ordinary mode activates the bank. A valid return whose saved address has bit 0 clear deactivates it again. A request to move the bank into the state it already holds does not change the bank and raises a one-cycle error pulse.

Requests are plain one-cycle strobes sampled at the clock edge, and there is no back-pressure. The redirect result appears one cycle later with `redirect_vld`, and the fetch side must accept it in that cycle. Instruction fetch and decode are outside this block.

Top module: `trap_entry_seq`

## Requirements
- R1: During and after reset, `next_pc` = BOOT_BASE + 0x0001 and `next_npc` = `next_pc` + 4. The shadow bank is active, `restart_addr` is 0, and `redirect_vld` and `swap_err` are 0.
- R2: A trap (`trap_valid`=1) sets `next_pc` = `vec_base` + offset(`trap_code`) and pulses `redirect_vld` for exactly one cycle; both appear one cycle after the request. The code-to-offset map is:
  - 0 → 0x0001
  - 1 → 0x0401
  - 2 → 0x0501
  - 3 (interrupt) → 0x0101
  - 4 → 0x0201
  - 5 → 0x0281
  - 6 → 0x0301
  - 7 → 0x0381
  - 8 → 0x0181
  - 9 → 0x0081
  - 10 (unimplemented operation) → 0x0481
  - 11 → 0x0581
  - 12 (privileged call) → 0x2001
  - 13 → 0x0501
  - 14 and 15 → 0x0401
- R3: On every redirect, `next_npc` equals `next_pc` + 4.
- R4: A trap saves `cur_pc` in `restart_addr`, except for code 12, which saves `cur_pc` + 4.
- R5: An interrupt (code 3) taken with `cur_pc[0]`=1 leaves `restart_addr` unchanged.
- R6: A trap with `cur_pc[0]`=0 activates the shadow bank. A trap with `cur_pc[0]`=1 leaves the bank state unchanged.
- R7: Indices 8 to 14 and 25 reach their shadow copy while `shadow_active`=1 and their normal copy otherwise. All other indices have a single copy. Reads are combinational; writes take effect at the clock edge.
- R8: A return request with `cur_pc[0]`=0 is taken as a code-10 trap. `restart_addr` becomes `cur_pc`, and the bank rules of R6 and R10 apply.
- R9: A return request with `cur_pc[0]`=1 sets `next_pc` to `restart_addr`, sets `next_npc` to `restart_addr` + 4, and keeps `restart_addr`. It deactivates the shadow bank only when `restart_addr[0]`=0.
- R10: A bank switch requested into the state already held pulses `swap_err` for one cycle. The bank state and all register contents stay unchanged, and the redirect still happens.
- R11: When a trap and a return request arrive in the same cycle, only the trap is performed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_valid | input | 1 | Trap request strobe |
| trap_code | input | 4 | Trap cause code |
| cur_pc | input | XLEN | PC of the current instruction; bit 0 marks privileged mode |
| ret_req | input | 1 | Return-from-exception request strobe |
| vec_base | input | XLEN | Handler vector base |
| rf_wr_en | input | 1 | Register write enable |
| rf_wr_idx | input | IDX_W | Register write index |
| rf_wr_data | input | XLEN | Register write data |
| rf_rd_idx | input | IDX_W | Register read index |
| rf_rd_data | output | XLEN | Register read data |
| redirect_vld | output | 1 | One-cycle pulse: new PC pair is valid |
| next_pc | output | XLEN | Next PC |
| next_npc | output | XLEN | Next-next PC |
| restart_addr | output | XLEN | Saved restart address |
| shadow_active | output | 1 | Shadow bank in use |
| swap_err | output | 1 | One-cycle pulse: redundant bank switch requested |

## Verification
The bench builds the block with XLEN=32, 32 registers, a shadow range of 8 to 14 plus 25, and BOOT_BASE=0x8000. A handler base of 0x0010_0000 makes each vector offset visible unchanged in the low bits of `next_pc`. A vector table steps through every cause code, including one undefined code, while the core stays privileged. This drives the offset map, the skip for privileged calls and the kept address for interrupts without touching the bank. Directed sequences then alternate between ordinary and privileged entry to reach both redundant-switch cases, the bank-select behaviour of one redirected and one plain register, and the trap-over-return priority.

// File: rtl/trap_seq_pkg.sv
package trap_seq_pkg;

  localparam int CODE_W = 4;
  localparam int OFF_W  = 16;

  typedef enum logic [CODE_W-1:0] {
    TC_BOOT      = 4'd0,
    TC_MCHK      = 4'd1,
    TC_ARITH     = 4'd2,
    TC_INTR      = 4'd3,
    TC_DMISS_USR = 4'd4,
    TC_DMISS_PRV = 4'd5,
    TC_ALIGN     = 4'd6,
    TC_DFAULT    = 4'd7,
    TC_IMISS     = 4'd8,
    TC_IACV      = 4'd9,
    TC_BADOP     = 4'd10,
    TC_FPOFF     = 4'd11,
    TC_PRIVCALL  = 4'd12,
    TC_IOVF      = 4'd13
  } trap_code_e;

  // Vector offset per cause; each carries the privileged bit (bit 0).
  function automatic logic [OFF_W-1:0] vec_offset(input logic [CODE_W-1:0] code);
    logic [OFF_W-1:0] off;
    case (code)
      TC_BOOT:      off = 16'h0001;
      TC_MCHK:      off = 16'h0401;
      TC_ARITH:     off = 16'h0501;
      TC_INTR:      off = 16'h0101;
      TC_DMISS_USR: off = 16'h0201;
      TC_DMISS_PRV: off = 16'h0281;
      TC_ALIGN:     off = 16'h0301;
      TC_DFAULT:    off = 16'h0381;
      TC_IMISS:     off = 16'h0181;
      TC_IACV:      off = 16'h0081;
      TC_BADOP:     off = 16'h0481;
      TC_FPOFF:     off = 16'h0581;
      TC_PRIVCALL:  off = 16'h2001;
      TC_IOVF:      off = 16'h0501;
      default:      off = 16'h0401;
    endcase
    return off;
  endfunction

endpackage

// File: rtl/trap_vec_lookup.sv
module trap_vec_lookup
  import trap_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   base,
  output logic [XLEN-1:0]   handler_pc
);

  logic [OFF_W-1:0] off;

  always_comb begin
    off        = vec_offset(code);
    handler_pc = base + XLEN'(off);
  end

endmodule

// File: rtl/restart_calc.sv
module restart_calc
  import trap_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [CODE_W-1:0] code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_restart,
  output logic [XLEN-1:0]   new_restart
);

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);

  logic priv;

  always_comb begin
    priv = cur_pc[0];
    if ((code == TC_INTR) && priv) begin
      new_restart = cur_restart;
    end else if (code == TC_PRIVCALL) begin
      new_restart = cur_pc + INSN_BYTES;
    end else begin
      new_restart = cur_pc;
    end
  end

endmodule

// File: rtl/shadow_rf.sv
module shadow_rf #(
  parameter int XLEN         = 32,
  parameter int NREGS        = 32,
  parameter int SHADOW_LO    = 8,
  parameter int SHADOW_HI    = 14,
  parameter int SHADOW_EXTRA = 25,
  parameter int IDX_W        = $clog2(NREGS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shadow_act,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data
);

  logic [NREGS-1:0] redir;
  logic [XLEN-1:0]  norm_q [NREGS];
  logic [XLEN-1:0]  shd_q  [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_redir
    assign redir[g] = ((g >= SHADOW_LO) && (g <= SHADOW_HI)) || (g == SHADOW_EXTRA);
  end

  logic wr_to_shd;
  logic rd_from_shd;

  always_comb begin
    wr_to_shd   = shadow_act && redir[wr_idx];
    rd_from_shd = shadow_act && redir[rd_idx];
    rd_data     = rd_from_shd ? shd_q[rd_idx] : norm_q[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) begin
        norm_q[i] <= '0;
        shd_q[i]  <= '0;
      end
    end else if (wr_en) begin
      if (wr_to_shd) begin
        shd_q[wr_idx] <= wr_data;
      end else begin
        norm_q[wr_idx] <= wr_data;
      end
    end
  end

  // R7
  plain_reg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!redir[rd_idx] && $stable(rd_idx) && !$past(wr_en)) |-> $stable(rd_data));

endmodule

// File: rtl/trap_entry_seq.sv
module trap_entry_seq
  import trap_seq_pkg::*;
#(
  parameter int              XLEN         = 32,
  parameter int              NREGS        = 32,
  parameter int              SHADOW_LO    = 8,
  parameter int              SHADOW_HI    = 14,
  parameter int              SHADOW_EXTRA = 25,
  parameter logic [XLEN-1:0] BOOT_BASE    = 32'h0000_8000,
  parameter int              IDX_W        = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trap_valid,
  input  logic [CODE_W-1:0] trap_code,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic              ret_req,
  input  logic [XLEN-1:0]   vec_base,
  input  logic              rf_wr_en,
  input  logic [IDX_W-1:0]  rf_wr_idx,
  input  logic [XLEN-1:0]   rf_wr_data,
  input  logic [IDX_W-1:0]  rf_rd_idx,
  output logic [XLEN-1:0]   rf_rd_data,
  output logic              redirect_vld,
  output logic [XLEN-1:0]   next_pc,
  output logic [XLEN-1:0]   next_npc,
  output logic [XLEN-1:0]   restart_addr,
  output logic              shadow_active,
  output logic              swap_err
);

  localparam logic [XLEN-1:0] INSN_BYTES = XLEN'(4);
  localparam logic [XLEN-1:0] BOOT_PC    = BOOT_BASE + XLEN'(vec_offset(TC_BOOT));

  logic [XLEN-1:0] pc_q, npc_q, restart_q;
  logic            shadow_q, err_q, redir_q;

  // Request decode
  logic              priv, take_trap, take_ret;
  logic [CODE_W-1:0] eff_code;
  logic [XLEN-1:0]   handler_pc, restart_new;

  always_comb begin
    priv      = cur_pc[0];
    take_trap = trap_valid || (ret_req && !priv);
    take_ret  = ret_req && !trap_valid && priv;
    eff_code  = trap_valid ? trap_code : TC_BADOP;
  end

  trap_vec_lookup #(.XLEN(XLEN)) u_vec (
    .code       (eff_code),
    .base       (vec_base),
    .handler_pc (handler_pc)
  );

  restart_calc #(.XLEN(XLEN)) u_restart (
    .code        (eff_code),
    .cur_pc      (cur_pc),
    .cur_restart (restart_q),
    .new_restart (restart_new)
  );

  // Bank switch control
  logic swap_in, swap_out, swap_req, swap_target, swap_bad, shadow_d;

  always_comb begin
    swap_in     = take_trap && !priv;
    swap_out    = take_ret && !restart_q[0];
    swap_req    = swap_in || swap_out;
    swap_target = swap_in;
    swap_bad    = swap_req && (shadow_q == swap_target);
    shadow_d    = (swap_req && !swap_bad) ? swap_target : shadow_q;
  end

  // PC selection
  logic [XLEN-1:0] pc_d, npc_d, restart_d;
  logic            redir_d;

  always_comb begin
    redir_d   = take_trap || take_ret;
    pc_d      = pc_q;
    restart_d = restart_q;
    if (take_trap) begin
      pc_d      = handler_pc;
      restart_d = restart_new;
    end else if (take_ret) begin
      pc_d      = restart_q;
    end
    npc_d = redir_d ? (pc_d + INSN_BYTES) : npc_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q      <= BOOT_PC;
      npc_q     <= BOOT_PC + INSN_BYTES;
      restart_q <= '0;
      shadow_q  <= 1'b1;
      err_q     <= 1'b0;
      redir_q   <= 1'b0;
    end else begin
      pc_q      <= pc_d;
      npc_q     <= npc_d;
      restart_q <= restart_d;
      shadow_q  <= shadow_d;
      err_q     <= swap_bad;
      redir_q   <= redir_d;
    end
  end

  shadow_rf #(
    .XLEN(XLEN), .NREGS(NREGS), .SHADOW_LO(SHADOW_LO),
    .SHADOW_HI(SHADOW_HI), .SHADOW_EXTRA(SHADOW_EXTRA), .IDX_W(IDX_W)
  ) u_rf (
    .clk        (clk),
    .rst_n      (rst_n),
    .shadow_act (shadow_q),
    .wr_en      (rf_wr_en),
    .wr_idx     (rf_wr_idx),
    .wr_data    (rf_wr_data),
    .rd_idx     (rf_rd_idx),
    .rd_data    (rf_rd_data)
  );

  assign redirect_vld  = redir_q;
  assign next_pc       = pc_q;
  assign next_npc      = npc_q;
  assign restart_addr  = restart_q;
  assign shadow_active = shadow_q;
  assign swap_err      = err_q;

  // R3
  npc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_vld |-> (next_npc == next_pc + INSN_BYTES));

  // R6
  swap_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && !cur_pc[0]) |=> shadow_active);

  // R10
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swap_err |-> (shadow_active == $past(shadow_active)));

  // R9
  ret_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !trap_valid && cur_pc[0] && restart_addr[0]) |=>
      ((shadow_active == $past(shadow_active)) && (next_pc == $past(restart_addr))));

  // R11
  trap_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_valid && ret_req && cur_pc[0] && (trap_code != TC_INTR) && (trap_code != TC_PRIVCALL))
      |=> (restart_addr == $past(cur_pc)));

endmodule

// File: tb/tb_trap_entry_seq.sv
module tb_trap_entry_seq;

  localparam int XLEN = 32;
  localparam int IDX_W = 5;
  localparam logic [31:0] BASE = 32'h0010_0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic trap_valid = 1'b0;
  logic [3:0] trap_code = '0;
  logic [XLEN-1:0] cur_pc = '0;
  logic ret_req = 1'b0;
  logic [XLEN-1:0] vec_base = BASE;
  logic rf_wr_en = 1'b0;
  logic [IDX_W-1:0] rf_wr_idx = '0;
  logic [XLEN-1:0] rf_wr_data = '0;
  logic [IDX_W-1:0] rf_rd_idx = '0;
  logic [XLEN-1:0] rf_rd_data;
  logic redirect_vld, shadow_active, swap_err;
  logic [XLEN-1:0] next_pc, next_npc, restart_addr;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_exc;

  always #5 clk = ~clk;

  trap_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .trap_valid(trap_valid), .trap_code(trap_code),
    .cur_pc(cur_pc), .ret_req(ret_req), .vec_base(vec_base),
    .rf_wr_en(rf_wr_en), .rf_wr_idx(rf_wr_idx), .rf_wr_data(rf_wr_data),
    .rf_rd_idx(rf_rd_idx), .rf_rd_data(rf_rd_data),
    .redirect_vld(redirect_vld), .next_pc(next_pc), .next_npc(next_npc),
    .restart_addr(restart_addr), .shadow_active(shadow_active), .swap_err(swap_err)
  );

  // {code, cur_pc, offset, kind}: kind 0 saves pc, 1 saves pc+4, 2 keeps previous
  localparam logic [53:0] VEC [15] = '{
    {4'd0,  32'h0000_1001, 16'h0001, 2'd0},
    {4'd1,  32'h0000_1011, 16'h0401, 2'd0},
    {4'd2,  32'h0000_1021, 16'h0501, 2'd0},
    {4'd3,  32'h0000_1031, 16'h0101, 2'd2},
    {4'd4,  32'h0000_1041, 16'h0201, 2'd0},
    {4'd5,  32'h0000_1051, 16'h0281, 2'd0},
    {4'd6,  32'h0000_1061, 16'h0301, 2'd0},
    {4'd7,  32'h0000_1071, 16'h0381, 2'd0},
    {4'd8,  32'h0000_1081, 16'h0181, 2'd0},
    {4'd9,  32'h0000_1091, 16'h0081, 2'd0},
    {4'd10, 32'h0000_10A1, 16'h0481, 2'd0},
    {4'd11, 32'h0000_10B1, 16'h0581, 2'd0},
    {4'd12, 32'h0000_10C1, 16'h2001, 2'd1},
    {4'd13, 32'h0000_10D1, 16'h0501, 2'd0},
    {4'd15, 32'h0000_10E1, 16'h0401, 2'd0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic req(input logic tv, input logic [3:0] code, input logic [31:0] pc, input logic rr);
    @(negedge clk);
    trap_valid = tv; trap_code = code; cur_pc = pc; ret_req = rr;
    @(posedge clk);
    @(negedge clk);
    trap_valid = 1'b0; ret_req = 1'b0;
  endtask

  task automatic rf_write(input logic [4:0] idx, input logic [31:0] d);
    @(negedge clk);
    rf_wr_en = 1'b1; rf_wr_idx = idx; rf_wr_data = d;
    @(posedge clk);
    @(negedge clk);
    rf_wr_en = 1'b0;
  endtask

  task automatic rf_read(input logic [4:0] idx, input logic [31:0] exp, input string tag);
    rf_rd_idx = idx;
    #1;
    chk(tag, rf_rd_data, exp);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk("R1 pc", next_pc, 32'h0000_8001);
    chk("R1 npc", next_npc, 32'h0000_8005);
    chk("R1 shadow", {31'b0, shadow_active}, 32'd1);
    chk("R1 restart", restart_addr, 32'd0);
    chk("R1 vld/err", {30'b0, redirect_vld, swap_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", next_pc, 32'h0000_8001);

    // Vector table, privileged entry: R2 R3 R4 R5
    exp_exc = 32'd0;
    for (int i = 0; i < 15; i++) begin
      req(1'b1, VEC[i][53:50], VEC[i][49:18], 1'b0);
      if (VEC[i][1:0] == 2'd0) exp_exc = VEC[i][49:18];
      else if (VEC[i][1:0] == 2'd1) exp_exc = VEC[i][49:18] + 32'd4;
      chk("R2 handler pc", next_pc, BASE + {16'h0, VEC[i][17:2]});
      chk("R3 npc", next_npc, BASE + {16'h0, VEC[i][17:2]} + 32'd4);
      chk("R2 vld", {31'b0, redirect_vld}, 32'd1);
      chk(VEC[i][1:0] == 2'd2 ? "R5 restart kept" : "R4 restart", restart_addr, exp_exc);
      chk("R6 priv no swap", {30'b0, shadow_active, swap_err}, 32'b10);
    end
    @(negedge clk);
    chk("R2 vld pulse ends", {31'b0, redirect_vld}, 32'd0);

    rf_write(5'd9, 32'h0000_BBBB);

    // R9: return, saved bit0=1 -> no bank change
    req(1'b0, 4'd0, 32'h0000_7001, 1'b1);
    chk("R9 pc", next_pc, 32'h0000_10E1);
    chk("R9 npc", next_npc, 32'h0000_10E5);
    chk("R9 keep bank", {30'b0, shadow_active, swap_err}, 32'b10);

    // R10: ordinary-mode trap while bank already active
    req(1'b1, 4'd6, 32'h0000_2000, 1'b0);
    chk("R10 pc", next_pc, BASE + 32'h301);
    chk("R10 restart", restart_addr, 32'h0000_2000);
    chk("R10 err in", {30'b0, shadow_active, swap_err}, 32'b11);
    rf_read(5'd9, 32'h0000_BBBB, "R10 r9 untouched");

    // R9: return with saved bit0=0 -> bank out
    req(1'b0, 4'd0, 32'h0000_7001, 1'b1);
    chk("R9 pc even", next_pc, 32'h0000_2000);
    chk("R9 npc even", next_npc, 32'h0000_2004);
    chk("R9 bank out", {30'b0, shadow_active, swap_err}, 32'b00);
    rf_read(5'd9, 32'd0, "R7 r9 normal copy");
    rf_write(5'd9, 32'h0000_AAAA);
    rf_write(5'd3, 32'h0000_3333);

    // R10: return out while bank already inactive
    req(1'b0, 4'd0, 32'h0000_7001, 1'b1);
    chk("R10 err out", {30'b0, shadow_active, swap_err}, 32'b01);
    chk("R10 pc", next_pc, 32'h0000_2000);
    rf_read(5'd9, 32'h0000_AAAA, "R10 r9 kept");

    // R6: privileged trap leaves bank inactive
    req(1'b1, 4'd1, 32'h0000_6001, 1'b0);
    chk("R6 priv keep", {30'b0, shadow_active, swap_err}, 32'b00);
    chk("R4 restart", restart_addr, 32'h0000_6001);

    // R6: ordinary trap activates bank; R7 banking
    req(1'b1, 4'd4, 32'h0000_3000, 1'b0);
    chk("R6 swap in", {30'b0, shadow_active, swap_err}, 32'b10);
    chk("R2 pc", next_pc, BASE + 32'h201);
    rf_read(5'd9, 32'h0000_BBBB, "R7 r9 shadow copy");
    rf_read(5'd3, 32'h0000_3333, "R7 r3 single copy");
    rf_write(5'd25, 32'h0000_2525);
    rf_read(5'd25, 32'h0000_2525, "R7 r25 shadow write");

    // R8: return from ordinary mode
    req(1'b0, 4'd0, 32'h0000_4000, 1'b1);
    chk("R8 pc", next_pc, BASE + 32'h481);
    chk("R8 restart", restart_addr, 32'h0000_4000);
    chk("R8 bank", {30'b0, shadow_active, swap_err}, 32'b11);

    // R11: trap and return together
    req(1'b1, 4'd7, 32'h0000_5001, 1'b1);
    chk("R11 pc", next_pc, BASE + 32'h381);
    chk("R11 restart", restart_addr, 32'h0000_5001);
    chk("R11 vld", {31'b0, redirect_vld}, 32'd1);

    finish_run();
  end

endmodule